// File: doc/BRIEF.md
# Protected ROM Verification Unit

This block is a production-test controller wrapped around an internal 16K-byte program ROM. It gives two ways to confirm the ROM content. The choice between them depends on a fixed protection configuration input. When the ROM is unprotected, an external 14-bit address selects a byte. That byte is returned on a byte-wide output after a fixed two-cycle delay.

When the ROM is protected, its bytes never leave the block. The block generates the ROM addresses itself and accepts one expected byte per step on a valid/ready stream. It compares each expected byte internally with the ROM byte and reports a single pass/fail bit for every group of 16 compared bytes.

The expected-byte stream has no buffering. `exp_ready` is high for as long as compare mode is active, and a byte is taken on every rising edge where `exp_valid` and `exp_ready` are both high. A source may hold `exp_valid` low for any number of cycles. Nothing advances during those cycles. Outside compare mode `exp_ready` is low and the stream is stalled. The ROM content is a fixed arithmetic function of the address, so the block needs no external memory file.

Top module: `rom_verify_unit`

## Requirements
- R1: After reset, `data_oe`, `exp_ready` and `grp_ok` are all 0.
- R2: `data_oe` is 1 exactly when `protect_cfg` is 0, `test_en` is 1 and `addr_hi[7:6]` is 2'b00 (direct readout mode).
- R3: The readout address is `{addr_hi[5:0], addr_lo}`. The ROM byte at address a is `a[7:0] ^ {a[13:8], 2'b01} ^ 8'h5A`.
- R4: `data_o` carries the ROM byte of the readout address sampled two rising edges earlier.
- R5: While `protect_cfg` is 1, `data_oe` stays 0 for every combination of the other inputs, so no ROM byte is presented.
- R6: `exp_ready` is 1 exactly when `protect_cfg` is 1 and `test_en` is 1 (compare mode). A byte is accepted on each rising edge with `exp_valid` and `exp_ready` both high. Idle cycles accept nothing.
- R7: In compare mode the internal address starts at 0 on every entry. It rises by 1 per accepted byte and wraps from 0x3FFF to 0. The address inputs have no effect on it.
- R8: On the 16th accepted byte of a group, `grp_ok` becomes 1 if all 16 bytes of that group matched their ROM bytes, else 0.
- R9: A mismatch affects only its own group. The next group starts with a clean record.
- R10: Leaving compare mode discards a partial group. The next entry starts a fresh group at address 0, and `grp_ok` keeps its last value in the meantime.
- R11: `grp_ok` changes only on the rising edge that accepts the 16th byte of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| protect_cfg | input | 1 | Fixed protection setting, 1 = protected |
| test_en | input | 1 | Test control inputs at their verification levels |
| addr_lo | input | 8 | Readout address bits 7:0 |
| addr_hi | input | 8 | Bits 5:0 are readout address bits 13:8; bits 7:6 must be 0 for readout |
| data_o | output | 8 | Readout data byte |
| data_oe | output | 1 | Data port drive enable; 0 means the port is released |
| exp_data | input | 8 | Expected ROM byte |
| exp_valid | input | 1 | Expected byte is present |
| exp_ready | output | 1 | Compare mode is active and a byte can be taken |
| grp_ok | output | 1 | Result of the last completed 16-byte group |

## Verification
The following rules are checked on every cycle:
- `data_oe` is never high under protection or with a nonzero top address bit.
- `exp_ready` follows the protection and enable inputs.
- Readout data matches the ROM function of the address from two edges before whenever the port is driven.
- `grp_ok` never moves on a cycle without an accepted byte.

The bench scenarios show the rest:
- the group bookkeeping: which byte in a group closes it, that a mismatch clears at a group boundary, that a partial group is discarded on exit, and that the internal address restarts and wraps;
- the full-address readout sweep.

// File: rtl/rvu_pkg.sv
package rvu_pkg;
  localparam int ROM_AW = 14;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_READ = 2'd1,
    MODE_CMP  = 2'd2
  } rvu_mode_e;

  function automatic logic [BYTE_W-1:0] rom_byte(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h5A;
  endfunction
endpackage

// File: rtl/rvu_mode_dec.sv
module rvu_mode_dec
  import rvu_pkg::*;
(
  input  logic       protect_cfg,
  input  logic       test_en,
  input  logic [1:0] hi_top,
  output rvu_mode_e  mode
);
  always_comb begin
    mode = MODE_IDLE;
    if (test_en) begin
      if (protect_cfg)          mode = MODE_CMP;
      else if (hi_top == 2'b00) mode = MODE_READ;
    end
  end
endmodule

// File: rtl/rvu_readout.sv
module rvu_readout
  import rvu_pkg::*;
#(
  parameter int AW = ROM_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data   <= '0;
    end else begin
      addr_q <= addr;
      data   <= rom_byte(addr_q);
    end
  end
endmodule

// File: rtl/rvu_compare.sv
module rvu_compare
  import rvu_pkg::*;
#(
  parameter int AW        = ROM_AW,
  parameter int DW        = BYTE_W,
  parameter int GROUP_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          take,
  input  logic [DW-1:0] expect_byte,
  output logic          grp_ok
);
  localparam int CNT_W = $clog2(GROUP_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_LEN - 1);

  logic [AW-1:0]    pos_q;
  logic [CNT_W-1:0] beat_q;
  logic             miss_q;
  logic             miss_now;

  assign miss_now = (expect_byte != rom_byte(pos_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      beat_q <= '0;
      miss_q <= 1'b0;
      grp_ok <= 1'b0;
    end else if (!active) begin
      pos_q  <= '0;
      beat_q <= '0;
      miss_q <= 1'b0;
    end else if (take) begin
      pos_q <= pos_q + 1'b1;
      if (beat_q == LAST) begin
        grp_ok <= !(miss_q || miss_now);
        beat_q <= '0;
        miss_q <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
        miss_q <= miss_q || miss_now;
      end
    end
  end
endmodule

// File: rtl/rom_verify_unit.sv
module rom_verify_unit
  import rvu_pkg::*;
#(
  parameter int GROUP_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       protect_cfg,
  input  logic       test_en,
  input  logic [7:0] addr_lo,
  input  logic [7:0] addr_hi,
  output logic [7:0] data_o,
  output logic       data_oe,
  input  logic [7:0] exp_data,
  input  logic       exp_valid,
  output logic       exp_ready,
  output logic       grp_ok
);
  rvu_mode_e     mode;
  logic [ROM_AW-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;

  assign rd_addr = {addr_hi[5:0], addr_lo};

  rvu_mode_dec u_dec (
    .protect_cfg (protect_cfg),
    .test_en     (test_en),
    .hi_top      (addr_hi[7:6]),
    .mode        (mode)
  );

  rvu_readout #(.AW(ROM_AW), .DW(BYTE_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (rd_addr),
    .data  (rd_data)
  );

  rvu_compare #(.AW(ROM_AW), .DW(BYTE_W), .GROUP_LEN(GROUP_LEN)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (mode == MODE_CMP),
    .take        (exp_valid && (mode == MODE_CMP)),
    .expect_byte (exp_data),
    .grp_ok      (grp_ok)
  );

  assign data_oe   = (mode == MODE_READ);
  assign data_o    = data_oe ? rd_data : '0;
  assign exp_ready = (mode == MODE_CMP);
endmodule

// File: rtl/rvu_checker.sv
module rvu_checker
  import rvu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       protect_cfg,
  input logic       test_en,
  input logic [7:0] addr_lo,
  input logic [7:0] addr_hi,
  input logic [7:0] data_o,
  input logic       data_oe,
  input logic       exp_valid,
  input logic       exp_ready,
  input logic       grp_ok
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  AST_PROT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    protect_cfg |-> !data_oe); // R5

  AST_TOP_BITS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi[7:6] != 2'b00) |-> !data_oe); // R2

  AST_READY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_ready == (protect_cfg && test_en)); // R6

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && since_rst >= 2'd2) |->
      data_o == rom_byte($past({addr_hi[5:0], addr_lo}, 2))); // R4

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exp_valid && exp_ready) |=> $stable(grp_ok)); // R11
endmodule

bind rom_verify_unit rvu_checker i_chk (.*);

// File: tb/test_rom_verify_unit.sv
`timescale 1ns/1ps
module test_rom_verify_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       protect_cfg = 1'b0;
  logic       test_en = 1'b0;
  logic [7:0] addr_lo = '0;
  logic [7:0] addr_hi = '0;
  logic [7:0] data_o;
  logic       data_oe;
  logic [7:0] exp_data = '0;
  logic       exp_valid = 1'b0;
  logic       exp_ready;
  logic       grp_ok;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rom_verify_unit i_rom_verify_unit (.*);

  function automatic logic [7:0] model_rom(input int a);
    logic [13:0] w;
    w = 14'(a);
    return w[7:0] ^ {w[13:8], 2'b01} ^ 8'h5A;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic prot);
    @(negedge clk);
    rst_n = 1'b0; protect_cfg = prot; test_en = 1'b0;
    exp_valid = 1'b0; addr_lo = '0; addr_hi = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One accepted byte; returns grp_ok seen after the accepting edge.
  task automatic push(input logic [7:0] b);
    exp_valid = 1'b1; exp_data = b;
    addr_lo = 8'($urandom); addr_hi = 8'($urandom);
    @(negedge clk);
    exp_valid = 1'b0;
  endtask

  initial begin
    logic prev;
    do_reset(1'b0);
    check("R1 data_oe", data_oe, 0);
    check("R1 exp_ready", exp_ready, 0);
    check("R1 grp_ok", grp_ok, 0);

    // R2 mode decode
    test_en = 1'b0; #1; check("R2 disabled", data_oe, 0);
    test_en = 1'b1;
    for (int t = 1; t < 4; t++) begin
      addr_hi = {2'(t), 6'h0}; #1;
      check("R2 top bits set", data_oe, 0);
    end
    addr_hi = 8'h00; #1; check("R2 readout entered", data_oe, 1);
    check("R6 no ready in readout", exp_ready, 0);

    // R3/R4 exhaustive readout sweep, one address per cycle
    for (int i = 0; i < 16384 + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check("R4 R3 readout byte", data_o, model_rom(i - 2));
      if (i < 16384) begin addr_lo = 8'(i); addr_hi = {2'b00, 6'(i >> 8)}; end
    end

    // R5 protection refuses readout for every address-high value
    do_reset(1'b1);
    test_en = 1'b1;
    for (int h = 0; h < 256; h++) begin
      addr_hi = 8'(h); addr_lo = 8'(h * 7); #1;
      check("R5 port released", data_oe, 0);
      check("R6 ready in compare", exp_ready, 1);
    end
    @(negedge clk);

    // R7/R8 full walk with idle gaps, then wrap to address 0
    for (int g = 0; g < 1025; g++) begin
      for (int k = 0; k < 16; k++) begin
        prev = grp_ok;
        push(model_rom((g * 16 + k) % 16384));
        if (k == 7) @(negedge clk);
        if (k != 15) check("R11 hold mid-group", grp_ok, prev);
      end
      check(g == 1024 ? "R7 wrap group ok" : "R8 group ok", grp_ok, 1);
    end

    // R8/R9 mismatches, restarted from address 0
    test_en = 1'b0; @(negedge clk); test_en = 1'b1;
    for (int g = 0; g < 48; g++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] b;
        b = model_rom(g * 16 + k);
        if (g % 3 == 0 && k == g % 16) b = b ^ 8'h10;
        push(b);
      end
      check(g % 3 == 0 ? "R8 mismatch group" : "R9 clean after mismatch",
            grp_ok, (g % 3 == 0) ? 0 : 1);
    end

    // R10 partial group discarded on exit
    test_en = 1'b0; @(negedge clk); test_en = 1'b1;
    for (int k = 0; k < 5; k++) push(8'hFF ^ model_rom(k));
    prev = grp_ok;
    test_en = 1'b0; @(negedge clk);
    check("R10 status held on exit", grp_ok, prev);
    check("R6 ready drops", exp_ready, 0);
    test_en = 1'b1;
    for (int k = 0; k < 16; k++) push(model_rom(k));
    check("R10 fresh group from 0", grp_ok, 1);
    for (int k = 0; k < 15; k++) push(model_rom(16 + k));
    push(8'h00 ^ model_rom(31) ^ 8'h01);
    check("R8 last byte mismatch", grp_ok, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule